// File: doc/BRIEF.md
# Batch-Grouped Bank Request Arbiter

This block chooses which pending request a single DRAM bank serves next. Requests arrive one per cycle. Each carries a thread number and a row address, and each is held in one of sixteen slots. Every slot also keeps a saturating age and a batch flag. When the bank can take a command (`issue_en`) and no flagged request is left, the block opens a new batch. It flags the oldest pending requests of every thread, but no more than `CAP` per thread. Flagged requests are always served before unflagged ones, so a thread that sends many requests cannot hold back the others for long.

Among the requests in the same batch class, the arbiter orders them by three keys in turn. First come requests that hit the currently open row. Next comes the thread with the best rank; the rank is supplied from outside and is derived from memory intensity, where lighter threads get a smaller value. Last, the oldest request wins. The winner is reported as a one-cycle grant that carries its slot index, thread and row, and its slot is released at the same clock edge.

Top module: `batch_req_sched`

## Requirements
- R1: When `req_valid` is high and a slot is free, the request is stored in the lowest-numbered free slot. `q_full` is high exactly when all 16 slots are occupied. A request presented while `q_full` is high is dropped and is never granted.
- R2: A grant is produced only at a clock edge where `issue_en` was high and at least one slot was occupied. It shows as `grant_valid` high for one cycle after that edge, with `grant_idx`, `grant_thread` and `grant_row` describing the chosen request. The granted slot is empty from that same edge.
- R3: Batch flags change only at an edge where `issue_en` is high. If no occupied slot is flagged at such an edge, a new batch is formed and takes part in the arbitration at that same edge. Requests that arrive while a batch is open stay unflagged.
- R4: When a batch forms, each thread gets at most `CAP` flagged requests (default 2), and these are its oldest ones.
- R5: A flagged request is always granted before any unflagged request, whatever their row, rank or age.
- R6: Within one batch class, a request whose row equals `open_row` while `open_valid` is high is granted before a request that misses. When `open_valid` is low, no request counts as a hit.
- R7: After batch class and hit status, the request from the thread with the smaller rank value wins. The rank of thread t is `thread_rank[3t+2:3t]`, and 0 is the best rank.
- R8: After rank, the request with the larger age wins. When ages are equal, which can happen once they saturate, the lower slot index wins. This keeps arrival order for requests from one thread.
- R9: While `rst_n` is low, all slots are emptied and all flags are cleared, and `grant_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A new request is presented |
| req_thread | input | 2 | Thread number of the new request |
| req_row | input | 8 | Row address of the new request |
| issue_en | input | 1 | The bank can accept a command this cycle |
| open_valid | input | 1 | A row is open in the bank |
| open_row | input | 8 | Row address currently open |
| thread_rank | input | 12 | Packed 3-bit rank per thread, 0 best |
| q_full | output | 1 | All slots are occupied |
| grant_valid | output | 1 | A one-cycle grant pulse |
| grant_idx | output | 4 | Slot index of the granted request |
| grant_thread | output | 2 | Thread of the granted request |
| grant_row | output | 8 | Row of the granted request |

## Verification
The bench sets up one case where a row-hit request from a heavy thread goes over its per-thread cap. That request must lose to a missing request of another thread that is in the batch; a design that ignores the cap, or that checks hits before batch flags, grants it first. A second case sends a hit request with the best rank while an older batch is still draining. A design that forms batches on every cycle, or that flags late arrivals, lets it jump ahead. A request offered while the queue is full must never come out, and a single thread's sixteen requests must drain in arrival order after ages saturate, so a wrong tie-break on equal ages shows up as reordered rows. Reset in the middle of a run, and arbitration with the row closed, check that stale entries vanish and that no stale row match is counted as a hit.

// File: rtl/bsched_pkg.sv
package bsched_pkg;
    parameter int ROW_W  = 8;
    parameter int THR_W  = 2;
    parameter int RANK_W = 3;
    parameter int AGE_W  = 4;

    typedef struct packed {
        logic             vld;
        logic             mrk;
        logic [THR_W-1:0] thr;
        logic [ROW_W-1:0] row;
        logic [AGE_W-1:0] age;
    } slot_t;
endpackage

// File: rtl/batch_marker.sv
module batch_marker
    import bsched_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CAP   = 2
) (
    input  slot_t [DEPTH-1:0] slots,
    output logic  [DEPTH-1:0] fresh_mark
);
    // A slot joins a new batch when fewer than CAP older slots of its thread exist.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int older;
            older = 0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && slots[j].vld && slots[j].thr == slots[i].thr &&
                    (slots[j].age > slots[i].age ||
                     (slots[j].age == slots[i].age && j < i)))
                    older++;
            end
            fresh_mark[i] = slots[i].vld && (older < CAP);
        end
    end
endmodule

// File: rtl/pick_arbiter.sv
module pick_arbiter
    import bsched_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NTHR  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  slot_t [DEPTH-1:0]       slots,
    input  logic  [DEPTH-1:0]       eff_mark,
    input  logic                    open_valid,
    input  logic  [ROW_W-1:0]       open_row,
    input  logic  [NTHR*RANK_W-1:0] thread_rank,
    output logic                    found,
    output logic  [IDX_W-1:0]       pick_idx
);
    logic              b_m, b_h, c_m, c_h, better;
    logic [RANK_W-1:0] b_r, c_r;
    logic [AGE_W-1:0]  b_a;

    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        b_m = 1'b0; b_h = 1'b0; b_r = '0; b_a = '0;
        c_m = 1'b0; c_h = 1'b0; c_r = '0; better = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slots[i].vld) begin
                c_m = eff_mark[i];
                c_h = open_valid && (slots[i].row == open_row);
                c_r = thread_rank[int'(slots[i].thr)*RANK_W +: RANK_W];
                better = !found || (c_m && !b_m) ||
                         (c_m == b_m && ((c_h && !b_h) ||
                          (c_h == b_h && (c_r < b_r ||
                           (c_r == b_r && slots[i].age > b_a)))));
                if (better) begin
                    found    = 1'b1;
                    pick_idx = IDX_W'(i);
                    b_m = c_m; b_h = c_h; b_r = c_r; b_a = slots[i].age;
                end
            end
        end
    end
endmodule

// File: rtl/batch_req_sched.sv
module batch_req_sched
    import bsched_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CAP   = 2,
    localparam int NTHR  = 1 << THR_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [THR_W-1:0]        req_thread,
    input  logic [ROW_W-1:0]        req_row,
    input  logic                    issue_en,
    input  logic                    open_valid,
    input  logic [ROW_W-1:0]        open_row,
    input  logic [NTHR*RANK_W-1:0]  thread_rank,
    output logic                    q_full,
    output logic                    grant_valid,
    output logic [IDX_W-1:0]        grant_idx,
    output logic [THR_W-1:0]        grant_thread,
    output logic [ROW_W-1:0]        grant_row
);
    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic              gv;
        logic [IDX_W-1:0]  gi;
        logic [THR_W-1:0]  gt;
        logic [ROW_W-1:0]  gr;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH-1:0]       vld_vec, mrk_vec, fresh_mark, eff_mark;
    logic [DEPTH*THR_W-1:0] thr_vec;
    logic                   found, free_found;
    logic [IDX_W-1:0]       pick_idx, free_idx;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld_vec[i] = st_q.slot[i].vld;
            mrk_vec[i] = st_q.slot[i].mrk;
            thr_vec[i*THR_W +: THR_W] = st_q.slot[i].thr;
        end
    end

    // Keep the open batch while any flagged slot remains, else use the new one.
    assign eff_mark = (|mrk_vec) ? mrk_vec : fresh_mark;

    batch_marker #(.DEPTH(DEPTH), .CAP(CAP)) i_marker (
        .slots      (st_q.slot),
        .fresh_mark (fresh_mark)
    );

    pick_arbiter #(.DEPTH(DEPTH), .NTHR(NTHR)) i_pick (
        .slots       (st_q.slot),
        .eff_mark    (eff_mark),
        .open_valid  (open_valid),
        .open_row    (open_row),
        .thread_rank (thread_rank),
        .found       (found),
        .pick_idx    (pick_idx)
    );

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!st_q.slot[i].vld) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        st_d    = st_q;
        st_d.gv = 1'b0;
        st_d.gi = '0;
        st_d.gt = '0;
        st_d.gr = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.slot[i].vld && st_q.slot[i].age != '1)
                st_d.slot[i].age = st_q.slot[i].age + 1'b1;
            if (issue_en)
                st_d.slot[i].mrk = eff_mark[i];
        end
        if (issue_en && found) begin
            st_d.gv = 1'b1;
            st_d.gi = pick_idx;
            st_d.gt = st_q.slot[pick_idx].thr;
            st_d.gr = st_q.slot[pick_idx].row;
            st_d.slot[pick_idx].vld = 1'b0;
            st_d.slot[pick_idx].mrk = 1'b0;
        end
        if (req_valid && free_found) begin
            st_d.slot[free_idx].vld = 1'b1;
            st_d.slot[free_idx].mrk = 1'b0;
            st_d.slot[free_idx].thr = req_thread;
            st_d.slot[free_idx].row = req_row;
            st_d.slot[free_idx].age = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_full       = !free_found;
    assign grant_valid  = st_q.gv;
    assign grant_idx    = st_q.gi;
    assign grant_thread = st_q.gt;
    assign grant_row    = st_q.gr;
endmodule

// File: rtl/bsched_checker.sv
module bsched_checker #(
    parameter int DEPTH = 16,
    parameter int CAP   = 2,
    parameter int THR_W = 2,
    parameter int IDX_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   issue_en,
    input logic [DEPTH-1:0]       vld_vec,
    input logic [DEPTH-1:0]       mrk_vec,
    input logic [DEPTH*THR_W-1:0] thr_vec,
    input logic                   grant_valid,
    input logic [IDX_W-1:0]       grant_idx
);
    localparam int NTHR = 1 << THR_W;
    int per_thr [NTHR];

    always_comb begin
        for (int t = 0; t < NTHR; t++) begin
            per_thr[t] = 0;
            for (int i = 0; i < DEPTH; i++)
                if (mrk_vec[i] && thr_vec[i*THR_W +: THR_W] == THR_W'(t))
                    per_thr[t]++;
        end
    end

    a_r2_grant_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ($past(issue_en) && $past(vld_vec) != '0));

    a_r2_slot_released: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !vld_vec[grant_idx]);

    a_r3_flags_only_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(issue_en) |-> $stable(mrk_vec));

    a_r3_flags_on_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        (mrk_vec & ~vld_vec) == '0);

    a_r5_batch_served_first: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && $past(mrk_vec) != '0) |->
            ((($past(mrk_vec)) >> grant_idx) & DEPTH'(1)) != '0);

    for (genvar t = 0; t < NTHR; t++) begin : g_cap
        a_r4_cap_per_thread: assert property (@(posedge clk) disable iff (!rst_n)
            per_thr[t] <= CAP);
    end
endmodule

bind batch_req_sched bsched_checker #(
    .DEPTH(DEPTH), .CAP(CAP), .THR_W(THR_W), .IDX_W(IDX_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_en    (issue_en),
    .vld_vec     (vld_vec),
    .mrk_vec     (mrk_vec),
    .thr_vec     (thr_vec),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx)
);

// File: tb/test_batch_req_sched.sv
module test_batch_req_sched;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       enq;
        logic [1:0] thr;
        logic [7:0] row;
        logic       iss;
        logic       ev;
        logic [1:0] ethr;
        logic [7:0] erow;
        logic [3:0] req;
    } step_t;

    // Rank: thread0=3, thread1=1, thread2=0, thread3=5. Open row 8'h10.
    localparam step_t TBL [20] = '{
        '{1'b1, 2'd0, 8'h20, 1'b0, 1'b0, 2'd0, 8'h00, 4'd1},
        '{1'b1, 2'd0, 8'h21, 1'b0, 1'b0, 2'd0, 8'h00, 4'd1},
        '{1'b1, 2'd0, 8'h10, 1'b0, 1'b0, 2'd0, 8'h00, 4'd1},
        '{1'b1, 2'd1, 8'h30, 1'b0, 1'b0, 2'd0, 8'h00, 4'd1},
        '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd1, 8'h30, 4'd4},  // R4 R7: capped hit loses
        '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd0, 8'h20, 4'd8},  // R8 oldest
        '{1'b1, 2'd2, 8'h10, 1'b1, 1'b1, 2'd0, 8'h21, 4'd5},  // R5 batch first
        '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd2, 8'h10, 4'd7},  // R3 new batch, R7 rank
        '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd0, 8'h10, 4'd7},
        '{1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h00, 4'd2},  // R2 empty
        '{1'b1, 2'd3, 8'h40, 1'b0, 1'b0, 2'd0, 8'h00, 4'd1},
        '{1'b1, 2'd3, 8'h10, 1'b0, 1'b0, 2'd0, 8'h00, 4'd1},
        '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd3, 8'h10, 4'd6},  // R6 hit over age
        '{1'b1, 2'd1, 8'h50, 1'b1, 1'b1, 2'd3, 8'h40, 4'd5},
        '{1'b1, 2'd1, 8'h51, 1'b0, 1'b0, 2'd0, 8'h00, 4'd2},
        '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd1, 8'h50, 4'd8},
        '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd1, 8'h51, 4'd8},
        '{1'b1, 2'd0, 8'h60, 1'b0, 1'b0, 2'd0, 8'h00, 4'd2},  // R2 no issue
        '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 4'd2},
        '{1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd0, 8'h60, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, issue_en, open_valid;
    logic [1:0]  req_thread;
    logic [7:0]  req_row, open_row;
    logic [11:0] thread_rank;
    logic        q_full, grant_valid;
    logic [3:0]  grant_idx;
    logic [1:0]  grant_thread;
    logic [7:0]  grant_row;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    batch_req_sched i_batch_req_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_thread(req_thread),
        .req_row(req_row), .issue_en(issue_en), .open_valid(open_valid),
        .open_row(open_row), .thread_rank(thread_rank), .q_full(q_full),
        .grant_valid(grant_valid), .grant_idx(grant_idx),
        .grant_thread(grant_thread), .grant_row(grant_row)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic e, input logic [1:0] t, input logic [7:0] r, input logic i);
        req_valid = e; req_thread = t; req_row = r; issue_en = i;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; issue_en = 1'b0;
    endtask

    task automatic expect_grant(input string tag, input logic ev, input logic [1:0] t,
                                input logic [7:0] r);
        chk({tag, " grant_valid"}, grant_valid, ev);
        if (ev) begin
            chk({tag, " grant_thread"}, grant_thread, t);
            chk({tag, " grant_row"}, grant_row, r);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; issue_en = 1'b0; req_thread = '0; req_row = '0;
        open_valid = 1'b1; open_row = 8'h10;
        thread_rank = {3'd5, 3'd0, 3'd1, 3'd3};
        @(negedge clk);
        do_reset();

        // R9: reset state
        chk("R9 grant_valid after reset", grant_valid, 1'b0);
        chk("R9 q_full after reset", q_full, 1'b0);

        for (int s = 0; s < 20; s++) begin
            drive(TBL[s].enq, TBL[s].thr, TBL[s].row, TBL[s].iss);
            expect_grant($sformatf("R%0d step %0d", TBL[s].req, s), TBL[s].ev,
                         TBL[s].ethr, TBL[s].erow);
        end

        // R1: fill all slots from thread 3, then offer one more while full
        do_reset();
        for (int k = 0; k < 16; k++) drive(1'b1, 2'd3, 8'h80 + 8'(k), 1'b0);
        chk("R1 q_full after 16 enqueues", q_full, 1'b1);
        drive(1'b1, 2'd2, 8'h10, 1'b0);
        chk("R1 no grant without issue", grant_valid, 1'b0);
        // R8: equal saturated ages drain in arrival order; R4 batches of CAP
        for (int k = 0; k < 16; k++) begin
            drive(1'b0, 2'd0, 8'h00, 1'b1);
            expect_grant($sformatf("R8 drain %0d", k), 1'b1, 2'd3, 8'h80 + 8'(k));
            if (k == 0) chk("R1 q_full clears after grant", q_full, 1'b0);
        end
        drive(1'b0, 2'd0, 8'h00, 1'b1);
        expect_grant("R1 dropped request never granted", 1'b0, 2'd0, 8'h00);

        // R9: reset in the middle of a run discards stored requests
        drive(1'b1, 2'd1, 8'h33, 1'b0);
        drive(1'b1, 2'd2, 8'h34, 1'b0);
        do_reset();
        drive(1'b0, 2'd0, 8'h00, 1'b1);
        expect_grant("R9 nothing left after reset", 1'b0, 2'd0, 8'h00);

        // R6: closed row means no hit, so age decides
        open_valid = 1'b0;
        drive(1'b1, 2'd1, 8'h20, 1'b0);
        drive(1'b1, 2'd1, 8'h10, 1'b0);
        drive(1'b0, 2'd0, 8'h00, 1'b1);
        expect_grant("R6 closed row no hit", 1'b1, 2'd1, 8'h20);
        open_valid = 1'b1;
        drive(1'b0, 2'd0, 8'h00, 1'b1);
        expect_grant("R6 remaining request", 1'b1, 2'd1, 8'h10);

        // R7: rank change from outside reorders two missing batch members
        thread_rank = {3'd5, 3'd0, 3'd1, 3'd0};
        drive(1'b1, 2'd1, 8'h44, 1'b0);
        drive(1'b1, 2'd0, 8'h45, 1'b0);
        drive(1'b0, 2'd0, 8'h00, 1'b1);
        expect_grant("R7 better rank wins over age", 1'b1, 2'd0, 8'h45);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule